// File: doc/BRIEF.md
# Multi-channel ADC conversion sequencer

This block schedules conversions for an external analog-to-digital converter that serves five input channels. A host programs it through a narrow register write port. One register holds a per-channel enable mask and a continuous-mode flag. A second register holds enables for three buffer amplifiers. A third address is a command that carries no data and starts one pass over the enabled channels.

The sequencer visits the enabled channels from the lowest index to the highest. For each channel it presents the index to the converter together with a one-cycle start pulse. It then waits for the converter's done handshake and captures the returned sample into that channel's result register. In continuous mode it keeps cycling and wraps back to the lowest enabled channel. Enable changes made during continuous mode steer the very next pick.

A ready flag (status bit 0) drops only while a single pass is in progress. A one-cycle interrupt request marks each return of the flag to high.

Top module: `adc_seq_top`

## Requirements
- R1: After reset the status byte reads 0x01, and irq_o, conv_start_o, amp_en_o and every result register read zero.
- R2: A write to address 1 sets amp_en_o to wr_data[2:0]; a 1 in a bit enables the amplifier of channel 2, 1 or 0 and a 0 powers it down and tri-states its output. Bits 7:3 of that write have no effect.
- R3: A write to address 2 (a start command) while idle and not in continuous mode makes the sequencer convert each channel enabled in wr_data[4:0] of the last address-0 write exactly once, in ascending order. The first conv_start_o pulse appears in the cycle after the command, and each later pulse appears in the cycle after the previous channel's conv_done_i.
- R4: Status bit 0 (ready) goes low in the cycle after an accepted start command. It returns high in the cycle after the last enabled channel's done, and irq_o is high for exactly that one cycle. Status bits 7:1 always read zero.
- R5: A start command with an all-zero enable mask launches no conversion, leaves ready high and raises no interrupt.
- R6: With bit 5 of address 0 set, conversions run without end over the enabled channels in ascending order, wrapping from the highest back to the lowest.
- R7: In continuous mode, a new enable mask written to address 0 selects the next channel that is launched after the write.
- R8: Start commands are ignored while bit 5 of address 0 is set, and ready never goes low while continuous mode is running.
- R9: Clearing bit 5 during a conversion lets that conversion finish and store its result, after which no further conversion starts.
- R10: A channel's result register loads conv_data_i only on conv_done_i while that channel is the one being converted. A done pulse seen while the sequencer is idle changes no result.
- R11: A start command issued while a single pass is still in progress is ignored and does not extend or restart the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Address: 0 channel control, 1 amplifier control, 2 start command |
| wr_data_i | input | 8 | Write data |
| status_o | output | 8 | Status byte, bit 0 is ready |
| irq_o | output | 1 | One-cycle pulse when ready rises |
| amp_en_o | output | 3 | Amplifier enables, low means powered down and high impedance |
| conv_start_o | output | 1 | One-cycle start pulse to the converter |
| conv_ch_o | output | 3 | Channel index being converted |
| conv_done_i | input | 1 | Converter done handshake |
| conv_data_i | input | 10 | Converter sample, valid with conv_done_i |
| result_o | output | 50 | Per-channel results, channel n in bits [10n+9:10n] |

## Verification
A corrupted pending mask or a bad current index shows up at the next done handshake. The following conv_start_o then carries the wrong channel on conv_ch_o, or a pulse is missing or extra, and the result lands in the wrong slot of result_o one cycle later. A ready or mode error shows in status_o within a cycle of the command or the final done, as a missing or stray irq_o pulse. The bench model predicts every port on every clock, so such a divergence is reported in the cycle it first becomes visible.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   localparam int REG_W = 8;

   typedef enum logic [1:0] {
      SEL_CH_CTRL  = 2'd0,
      SEL_AMP_CTRL = 2'd1,
      SEL_GO       = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH  = 5,
   parameter int NUM_AMP = 3,
   parameter int ADDR_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   output logic [NUM_CH-1:0] ch_en,
   output logic              auto_mode,
   output logic [NUM_AMP-1:0] amp_en,
   output logic              go
);
   localparam int AUTO_BIT = NUM_CH;

   if (NUM_CH < 2 || NUM_CH > REG_W - 1) begin : g_bad_ch
      $error("adc_seq_regs: NUM_CH must leave room for the mode bit");
   end
   if (NUM_AMP < 1 || NUM_AMP > NUM_CH) begin : g_bad_amp
      $error("adc_seq_regs: NUM_AMP out of range");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("adc_seq_regs: ADDR_W too small for the register map");
   end

   logic hit_ch, hit_amp;
   assign hit_ch  = wr_en && (wr_addr == ADDR_W'(SEL_CH_CTRL));
   assign hit_amp = wr_en && (wr_addr == ADDR_W'(SEL_AMP_CTRL));
   assign go      = wr_en && (wr_addr == ADDR_W'(SEL_GO));

   logic unused_hi;
   assign unused_hi = ^wr_data[REG_W-1:AUTO_BIT+1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ch_en     <= '0;
         auto_mode <= 1'b0;
         amp_en    <= '0;
      end else begin
         if (hit_ch) begin
            ch_en     <= wr_data[NUM_CH-1:0];
            auto_mode <= wr_data[AUTO_BIT];
         end
         if (hit_amp) begin
            amp_en <= wr_data[NUM_AMP-1:0];
         end
      end
   end

   assert_amp_follows_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      hit_amp |=> (amp_en == $past(wr_data[NUM_AMP-1:0])));
   assert_amp_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_amp |=> $stable(amp_en));
endmodule

// File: rtl/adc_seq_sched.sv
module adc_seq_sched #(
   parameter int NUM_CH = 5,
   parameter int CH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              auto_mode,
   input  logic              go,
   input  logic              conv_done,
   output logic              busy,
   output logic [CH_W-1:0]   cur_ch,
   output logic              conv_start,
   output logic              ready,
   output logic              irq
);
   if ((1 << CH_W) < NUM_CH) begin : g_bad_chw
      $error("adc_seq_sched: CH_W cannot index every channel");
   end

   logic              single_q;
   logic [NUM_CH-1:0] rem_q, rem_after;
   logic [CH_W-1:0]   first_idx, up_idx, rem_idx;
   logic              any_en, has_up, any_rem;

   // Lowest enabled channel, lowest enabled above the current one,
   // and lowest channel still owed in a single pass.
   always_comb begin
      first_idx = '0;
      up_idx    = '0;
      rem_idx   = '0;
      any_en    = 1'b0;
      has_up    = 1'b0;
      any_rem   = 1'b0;
      rem_after = rem_q;
      rem_after[cur_ch] = 1'b0;
      for (int i = NUM_CH - 1; i >= 0; i--) begin
         if (ch_en[i]) begin
            first_idx = CH_W'(i);
            any_en    = 1'b1;
            if (i > int'(cur_ch)) begin
               up_idx = CH_W'(i);
               has_up = 1'b1;
            end
         end
         if (rem_after[i]) begin
            rem_idx = CH_W'(i);
            any_rem = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         single_q   <= 1'b0;
         rem_q      <= '0;
         cur_ch     <= '0;
         conv_start <= 1'b0;
         ready      <= 1'b1;
         irq        <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         irq        <= 1'b0;
         if (!busy) begin
            if (auto_mode) begin
               if (any_en) begin
                  busy       <= 1'b1;
                  single_q   <= 1'b0;
                  cur_ch     <= first_idx;
                  conv_start <= 1'b1;
               end
            end else if (go && any_en) begin
               busy       <= 1'b1;
               single_q   <= 1'b1;
               rem_q      <= ch_en;
               cur_ch     <= first_idx;
               ready      <= 1'b0;
               conv_start <= 1'b1;
            end
         end else if (conv_done) begin
            if (single_q) begin
               rem_q <= rem_after;
               if (any_rem) begin
                  cur_ch     <= rem_idx;
                  conv_start <= 1'b1;
               end else begin
                  busy  <= 1'b0;
                  ready <= 1'b1;
                  irq   <= 1'b1;
               end
            end else if (auto_mode && any_en) begin
               cur_ch     <= has_up ? up_idx : first_idx;
               conv_start <= 1'b1;
            end else begin
               busy <= 1'b0;
            end
         end
      end
   end

   assert_start_only_in_scan_R3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);
   assert_ch_held_during_conv_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !conv_start) |-> $stable(cur_ch));
   assert_irq_on_ready_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (ready && !$past(ready)));
   assert_ready_low_single_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (busy && single_q));
   assert_ready_fall_needs_go_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready) |-> $past(go && !auto_mode));
   assert_idle_stays_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !auto_mode && !go) |=> !conv_start);
endmodule

// File: rtl/adc_seq_results.sv
module adc_seq_results #(
   parameter int NUM_CH = 5,
   parameter int DATA_W = 10,
   parameter int CH_W   = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     capture,
   input  logic [CH_W-1:0]          cur_ch,
   input  logic [DATA_W-1:0]        conv_data,
   output logic [NUM_CH*DATA_W-1:0] result_flat
);
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_dw
      $error("adc_seq_results: DATA_W out of range");
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
      logic load;
      assign load = capture && (cur_ch == CH_W'(g));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result_flat[g*DATA_W +: DATA_W] <= '0;
         end else if (load) begin
            result_flat[g*DATA_W +: DATA_W] <= conv_data;
         end
      end
   end

   assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> $stable(result_flat));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
   import adc_seq_pkg::*;
#(
   parameter int NUM_CH  = 5,
   parameter int NUM_AMP = 3,
   parameter int DATA_W  = 10,
   parameter int ADDR_W  = 2,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic [ADDR_W-1:0]        wr_addr_i,
   input  logic [REG_W-1:0]         wr_data_i,
   output logic [REG_W-1:0]         status_o,
   output logic                     irq_o,
   output logic [NUM_AMP-1:0]       amp_en_o,
   output logic                     conv_start_o,
   output logic [CH_W-1:0]          conv_ch_o,
   input  logic                     conv_done_i,
   input  logic [DATA_W-1:0]        conv_data_i,
   output logic [NUM_CH*DATA_W-1:0] result_o
);
   logic [NUM_CH-1:0] ch_en;
   logic              auto_mode, go, busy, ready;

   adc_seq_regs #(.NUM_CH(NUM_CH), .NUM_AMP(NUM_AMP), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
      .wr_data(wr_data_i), .ch_en(ch_en), .auto_mode(auto_mode),
      .amp_en(amp_en_o), .go(go)
   );

   adc_seq_sched #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_sched (
      .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .auto_mode(auto_mode),
      .go(go), .conv_done(conv_done_i), .busy(busy), .cur_ch(conv_ch_o),
      .conv_start(conv_start_o), .ready(ready), .irq(irq_o)
   );

   adc_seq_results #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) u_results (
      .clk(clk), .rst_n(rst_n), .capture(busy && conv_done_i),
      .cur_ch(conv_ch_o), .conv_data(conv_data_i), .result_flat(result_o)
   );

   assign status_o = {{(REG_W-1){1'b0}}, ready};
endmodule

// File: tb/adc_seq_top_tb.sv
module adc_seq_top_tb;
   localparam int NCH = 5;
   localparam int DW  = 10;
   localparam int LAT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic conv_done = 1'b0;
   logic [DW-1:0] conv_data = '0;
   logic [7:0] status;
   logic irq, conv_start;
   logic [2:0] amp_en, conv_ch;
   logic [NCH*DW-1:0] result;

   always #2 clk = ~clk;

   adc_seq_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .status_o(status), .irq_o(irq), .amp_en_o(amp_en),
      .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
      .conv_data_i(conv_data), .result_o(result)
   );

   int checks = 0, fails = 0, cyc = 0;
   int seen[$];
   int irq_cnt = 0, ready_low_cnt = 0, done_cnt = 0;
   int conv_last[NCH];
   int stray_req = 0, stray_done = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int low_from(input int mask, input int from);
      for (int k = from; k < NCH; k++) if (mask[k]) return k;
      return -1;
   endfunction

   function automatic int nxt(input int mask, input int p);
      for (int k = 1; k <= NCH; k++) begin
         int c = (p + k) % NCH;
         if (mask[c]) return c;
      end
      return -1;
   endfunction

   function automatic int res_of(input int c);
      return int'(result[c*DW +: DW]);
   endfunction

   // ---------------- behavioural reference model ----------------
   int m_en, m_auto, m_amp, m_busy, m_single, m_rem, m_cur, m_ready, m_irq, m_start;
   int m_res[NCH];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_en = 0; m_auto = 0; m_amp = 0; m_busy = 0; m_single = 0; m_rem = 0;
         m_cur = 0; m_ready = 1; m_irq = 0; m_start = 0;
         foreach (m_res[i]) m_res[i] = 0;
      end else begin
         int n;
         bit cmd;
         cmd = wr_en && wr_addr == 2'd2;
         m_start = 0; m_irq = 0;
         if (m_busy && conv_done) m_res[m_cur] = int'(conv_data);
         if (!m_busy) begin
            if (m_auto != 0) begin
               if (m_en != 0) begin m_busy = 1; m_single = 0; m_cur = low_from(m_en, 0); m_start = 1; end
            end else if (cmd && m_en != 0) begin
               m_busy = 1; m_single = 1; m_rem = m_en; m_cur = low_from(m_en, 0);
               m_ready = 0; m_start = 1;
            end
         end else if (conv_done) begin
            if (m_single != 0) begin
               m_rem = m_rem & ~(1 << m_cur);
               n = low_from(m_rem, 0);
               if (n >= 0) begin m_cur = n; m_start = 1; end
               else begin m_busy = 0; m_ready = 1; m_irq = 1; end
            end else if (m_auto != 0 && m_en != 0) begin
               m_cur = nxt(m_en, m_cur); m_start = 1;
            end else m_busy = 0;
         end
         if (wr_en && wr_addr == 2'd0) begin m_en = int'(wr_data[4:0]); m_auto = int'(wr_data[5]); end
         if (wr_en && wr_addr == 2'd1) m_amp = int'(wr_data[2:0]);
      end
   end

   // ---------------- per-clock comparison ----------------
   always @(negedge clk) begin
      if (rst_n) begin
         chk(int'(status) == m_ready, "R4", "status", int'(status), m_ready);
         chk(int'(irq) == m_irq, "R4", "irq", int'(irq), m_irq);
         chk(int'(conv_start) == m_start, "R3", "conv_start", int'(conv_start), m_start);
         if (conv_start) chk(int'(conv_ch) == m_cur, "R3", "conv_ch", int'(conv_ch), m_cur);
         chk(int'(amp_en) == m_amp, "R2", "amp_en", int'(amp_en), m_amp);
         for (int i = 0; i < NCH; i++)
            chk(res_of(i) == m_res[i], "R10", "result", res_of(i), m_res[i]);
         if (conv_start) seen.push_back(int'(conv_ch));
         if (irq) irq_cnt++;
         if (!status[0]) ready_low_cnt++;
      end
   end

   // ---------------- converter model ----------------
   int cnt = 0, seq = 0, pend_ch = 0;
   always @(negedge clk) begin
      conv_done = 1'b0;
      if (conv_start) begin
         cnt = LAT; pend_ch = int'(conv_ch);
      end else if (cnt > 0) begin
         cnt--;
         if (cnt == 0) begin
            seq++;
            conv_data = DW'((pend_ch * 97 + seq * 13 + 5) % 1024);
            conv_last[pend_ch] = int'(conv_data);
            conv_done = 1'b1;
            done_cnt++;
         end
      end else if (stray_req != stray_done) begin
         stray_done++;
         conv_data = DW'(10'h3FF);
         conv_done = 1'b1;
      end
   end

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 2'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_ready();
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (status[0]) break;
      end
      idle(2);
   endtask

   initial begin
      int snap[NCH];
      int ch0, d0;
      foreach (conv_last[i]) conv_last[i] = 0;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(status == 8'h01, "R1", "status", int'(status), 1);
      chk(!irq && !conv_start, "R1", "irq|start", int'({irq, conv_start}), 0);
      chk(amp_en == 3'b000, "R1", "amp_en", int'(amp_en), 0);
      chk(result == '0, "R1", "results nonzero", int'(result != '0), 0);

      // R2 amplifier enables, reserved bits ignored
      wr(1, 8'hFD);
      chk(amp_en == 3'b101, "R2", "amp_en", int'(amp_en), 5);
      wr(1, 8'hFA);
      chk(amp_en == 3'b010, "R2", "amp_en", int'(amp_en), 2);

      // R3/R4/R11 single pass over channels 1,2,4
      seen.delete(); irq_cnt = 0;
      wr(0, 8'b0001_0110);
      wr(2, 0);
      chk(status[0] == 1'b0, "R4", "ready after go", int'(status[0]), 0);
      idle(2);
      wr(2, 0); // R11: ignored while the pass runs
      wait_ready();
      chk(seen.size() == 3, "R11", "conversions", seen.size(), 3);
      if (seen.size() == 3) begin
         chk(seen[0] == 1, "R3", "order[0]", seen[0], 1);
         chk(seen[1] == 2, "R3", "order[1]", seen[1], 2);
         chk(seen[2] == 4, "R3", "order[2]", seen[2], 4);
      end
      chk(irq_cnt == 1, "R4", "irq pulses", irq_cnt, 1);
      chk(status == 8'h01, "R4", "status", int'(status), 1);
      chk(res_of(4) == conv_last[4], "R10", "res4", res_of(4), conv_last[4]);
      chk(res_of(0) == 0 && res_of(3) == 0, "R10", "untouched", res_of(0) + res_of(3), 0);

      // R5 empty mask
      seen.delete(); irq_cnt = 0;
      wr(0, 0);
      wr(2, 0);
      idle(10);
      chk(seen.size() == 0, "R5", "conversions", seen.size(), 0);
      chk(status[0] == 1'b1, "R5", "ready", int'(status[0]), 1);
      chk(irq_cnt == 0, "R5", "irq pulses", irq_cnt, 0);

      // R6 continuous mode over channels 0,2 ; R8 command ignored
      seen.delete(); ready_low_cnt = 0;
      wr(0, 8'h25);
      idle(12);
      wr(2, 0);
      idle(30);
      chk(seen.size() >= 4, "R6", "conversions", seen.size(), 4);
      if (seen.size() > 0) chk(seen[0] == 0, "R6", "first", seen[0], 0);
      for (int i = 1; i < seen.size(); i++)
         chk(seen[i] == nxt(5, seen[i-1]), "R6", "wrap order", seen[i], nxt(5, seen[i-1]));

      // R7 live enable change to channels 1,3,4
      seen.delete();
      wr(0, 8'h3A);
      idle(60);
      chk(seen.size() >= 6, "R7", "conversions", seen.size(), 6);
      for (int i = 1; i < seen.size(); i++)
         chk(seen[i] == nxt(26, seen[i-1]), "R7", "new order", seen[i], nxt(26, seen[i-1]));

      // R9 leave continuous mode mid-conversion
      for (int k = 0; k < 50; k++) begin
         @(negedge clk);
         if (conv_start) break;
      end
      ch0 = int'(conv_ch);
      d0 = done_cnt;
      wr(0, 8'h1A);
      seen.delete();
      idle(15);
      chk(seen.size() == 0, "R9", "starts after stop", seen.size(), 0);
      chk(done_cnt == d0 + 1, "R9", "in-flight done", done_cnt, d0 + 1);
      chk(res_of(ch0) == conv_last[ch0], "R9", "stored", res_of(ch0), conv_last[ch0]);
      chk(ready_low_cnt == 0, "R8", "ready low cycles", ready_low_cnt, 0);

      // R10 stray done while idle
      for (int i = 0; i < NCH; i++) snap[i] = res_of(i);
      stray_req++;
      idle(6);
      for (int i = 0; i < NCH; i++)
         chk(res_of(i) == snap[i], "R10", "stray done", res_of(i), snap[i]);
      chk(seen.size() == 0, "R10", "starts", seen.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule